// File: doc/BRIEF.md
# Microcoded Accumulator Datapath

This block is the register-transfer half of a microprogrammed processor. Every clock it takes three 3-bit microoperation fields, each with its own fixed code table, and applies the selected transfers, arithmetic, logic and shift operations to a 16-bit accumulator, a 16-bit data register, an 11-bit address register and an 11-bit program counter. It also owns a 2048-word by 16-bit memory. Every selected operation finishes in that same clock.

A separate sequencer supplies the fields and chooses the next microinstruction. For that decision the datapath gives it the accumulator sign, the data register sign, an accumulator-zero flag and the 4-bit opcode slice of the data register. A machine instruction word is laid out as follows: bit 15 is the indirect flag, bits 14..11 are the opcode and bits 10..0 are the operand address. Opcode 0000 adds memory to the accumulator. Opcode 0001 branches when the accumulator is negative. Opcode 0010 stores the accumulator. Opcode 0011 exchanges the accumulator with memory. Microcode made from the operations below can carry out all four.

For observation, the four registers are also brought out on ports. Memory is a plain array with no reset.

Top module: `uop_datapath`

## Requirements
- R1: While reset is high on a clock edge, the accumulator, data register, address register and program counter are all cleared to zero.
- R2: Field one, accumulator codes: 001 adds the data register to the accumulator, 010 clears the accumulator, 011 increments it and 100 copies the data register into it. All arithmetic wraps modulo 2^16.
- R3: Field one, address codes: 101 loads the address register from data register bits 10..0, and 110 loads it from the program counter.
- R4: Field one code 111 writes the data register into the memory word addressed by the address register. Field two code 100 reads that word back into the data register.
- R5: Field two, accumulator codes: 001 subtracts the data register from the accumulator (wrapping), 010 ORs the data register into it and 011 ANDs it.
- R6: Field two, data register codes: 100 loads it from memory, 101 copies the accumulator into it, 110 increments it (wrapping) and 111 replaces bits 10..0 with the program counter while keeping bits 15..11.
- R7: Field three, accumulator codes: 001 XORs the data register into it, 010 complements it, 011 shifts it left by one and 100 shifts it right by one. Both shifts fill with zero.
- R8: Field three, program counter codes: 101 increments it modulo 2048, and 110 loads it from the address register.
- R9: Field three code 111, and all three fields at 000, leave every register unchanged.
- R10: Operations in different fields in the same cycle all read the register values from before the clock edge.
- R11: The status outputs show accumulator bit 15, data register bit 15, a flag that is high exactly when the accumulator is zero, and data register bits 14..11.
- R12: The following hand-written microcode routines leave the expected register and memory state. The fetch routine is: address register from program counter; then memory to data register together with program counter increment; then address register from data register. The add routine follows it with a memory read and an accumulator add. The exchange routine follows it with a read, a simultaneous accumulator-from-data and data-from-accumulator transfer, and a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| f1_op | input | 3 | Microoperation field one |
| f2_op | input | 3 | Microoperation field two |
| f3_op | input | 3 | Microoperation field three |
| ac_q | output | 16 | Accumulator value |
| dr_q | output | 16 | Data register value |
| ar_q | output | 11 | Address register value |
| pc_q | output | 11 | Program counter value |
| ac_sign | output | 1 | Accumulator bit 15 |
| dr_sign | output | 1 | Data register bit 15 |
| ac_zero | output | 1 | High when the accumulator is zero |
| dr_opcode | output | 4 | Data register bits 14..11 |

## Verification
The hardest state to reach from the ports is a chosen word at a chosen memory address. No port carries data or addresses into the block, so every value has to be built from microoperations. The stimulus builds a constant by clearing the accumulator and then, for each bit from the top down, shifting left and incrementing where the bit is set. It copies that value into the data register and then into the address register, builds a second constant and writes it. With memory seeded this way, the fetch, add and exchange routines run on real instruction words, and their results are read back through the same load-address-then-read path.

// File: rtl/mdp_pkg.sv
package mdp_pkg;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 11;
    localparam int OPC_W  = 4;

    typedef enum logic [2:0] {
        F1_IDLE     = 3'b000,
        F1_ACC_ADD  = 3'b001,
        F1_ACC_CLR  = 3'b010,
        F1_ACC_INC  = 3'b011,
        F1_ACC_LDDR = 3'b100,
        F1_ADR_LDDR = 3'b101,
        F1_ADR_LDPC = 3'b110,
        F1_MEM_WR   = 3'b111
    } f1_e;

    typedef enum logic [2:0] {
        F2_IDLE      = 3'b000,
        F2_ACC_SUB   = 3'b001,
        F2_ACC_OR    = 3'b010,
        F2_ACC_AND   = 3'b011,
        F2_DAT_LDMEM = 3'b100,
        F2_DAT_LDAC  = 3'b101,
        F2_DAT_INC   = 3'b110,
        F2_DAT_LDPC  = 3'b111
    } f2_e;

    typedef enum logic [2:0] {
        F3_IDLE     = 3'b000,
        F3_ACC_XOR  = 3'b001,
        F3_ACC_NOT  = 3'b010,
        F3_ACC_SHL  = 3'b011,
        F3_ACC_SHR  = 3'b100,
        F3_PRG_INC  = 3'b101,
        F3_PRG_LDAR = 3'b110,
        F3_SPARE    = 3'b111
    } f3_e;

    typedef enum logic [3:0] {
        ACS_HOLD, ACS_ADD, ACS_SUB, ACS_OR, ACS_AND, ACS_XOR,
        ACS_CLR, ACS_INC, ACS_LDDR, ACS_NOT, ACS_SHL, ACS_SHR
    } ac_sel_e;

    typedef enum logic [2:0] {
        DRS_HOLD, DRS_MEM, DRS_AC, DRS_INC, DRS_PC
    } dr_sel_e;

    typedef enum logic [1:0] {
        ARS_HOLD, ARS_DR, ARS_PC
    } ar_sel_e;

    typedef enum logic [1:0] {
        PCS_HOLD, PCS_INC, PCS_AR
    } pc_sel_e;

    typedef struct packed {
        ac_sel_e ac_sel;
        dr_sel_e dr_sel;
        ar_sel_e ar_sel;
        pc_sel_e pc_sel;
        logic    mem_we;
    } ctl_t;

    function automatic ac_sel_e f1_ac(input f1_e c);
        case (c)
            F1_ACC_ADD:  return ACS_ADD;
            F1_ACC_CLR:  return ACS_CLR;
            F1_ACC_INC:  return ACS_INC;
            F1_ACC_LDDR: return ACS_LDDR;
            default:     return ACS_HOLD;
        endcase
    endfunction

    function automatic ac_sel_e f2_ac(input f2_e c);
        case (c)
            F2_ACC_SUB: return ACS_SUB;
            F2_ACC_OR:  return ACS_OR;
            F2_ACC_AND: return ACS_AND;
            default:    return ACS_HOLD;
        endcase
    endfunction

    function automatic ac_sel_e f3_ac(input f3_e c);
        case (c)
            F3_ACC_XOR: return ACS_XOR;
            F3_ACC_NOT: return ACS_NOT;
            F3_ACC_SHL: return ACS_SHL;
            F3_ACC_SHR: return ACS_SHR;
            default:    return ACS_HOLD;
        endcase
    endfunction

endpackage

// File: rtl/mdp_decode.sv
module mdp_decode
    import mdp_pkg::*;
(
    input  logic [2:0] f1_op,
    input  logic [2:0] f2_op,
    input  logic [2:0] f3_op,
    output ctl_t       ctl
);
    f1_e c1;
    f2_e c2;
    f3_e c3;
    ac_sel_e a1, a2, a3;

    always_comb begin
        c1 = f1_e'(f1_op);
        c2 = f2_e'(f2_op);
        c3 = f3_e'(f3_op);
        a1 = f1_ac(c1);
        a2 = f2_ac(c2);
        a3 = f3_ac(c3);

        ctl = '{ac_sel: ACS_HOLD, dr_sel: DRS_HOLD, ar_sel: ARS_HOLD,
                pc_sel: PCS_HOLD, mem_we: 1'b0};

        // One accumulator writer per cycle is legal; fixed order settles clashes.
        if (a1 != ACS_HOLD)      ctl.ac_sel = a1;
        else if (a2 != ACS_HOLD) ctl.ac_sel = a2;
        else                     ctl.ac_sel = a3;

        case (c2)
            F2_DAT_LDMEM: ctl.dr_sel = DRS_MEM;
            F2_DAT_LDAC:  ctl.dr_sel = DRS_AC;
            F2_DAT_INC:   ctl.dr_sel = DRS_INC;
            F2_DAT_LDPC:  ctl.dr_sel = DRS_PC;
            default:      ctl.dr_sel = DRS_HOLD;
        endcase

        case (c1)
            F1_ADR_LDDR: ctl.ar_sel = ARS_DR;
            F1_ADR_LDPC: ctl.ar_sel = ARS_PC;
            default:     ctl.ar_sel = ARS_HOLD;
        endcase
        ctl.mem_we = (c1 == F1_MEM_WR);

        case (c3)
            F3_PRG_INC:  ctl.pc_sel = PCS_INC;
            F3_PRG_LDAR: ctl.pc_sel = PCS_AR;
            default:     ctl.pc_sel = PCS_HOLD;
        endcase
    end
endmodule

// File: rtl/mdp_alu.sv
module mdp_alu
    import mdp_pkg::*;
#(
    parameter int DW = DATA_W
)(
    input  ac_sel_e         sel,
    input  logic [DW-1:0]   ac,
    input  logic [DW-1:0]   dr,
    output logic [DW-1:0]   y
);
    localparam logic [DW-1:0] ONE = DW'(1);

    always_comb begin
        case (sel)
            ACS_ADD:  y = ac + dr;
            ACS_SUB:  y = ac - dr;
            ACS_OR:   y = ac | dr;
            ACS_AND:  y = ac & dr;
            ACS_XOR:  y = ac ^ dr;
            ACS_CLR:  y = '0;
            ACS_INC:  y = ac + ONE;
            ACS_LDDR: y = dr;
            ACS_NOT:  y = ~ac;
            ACS_SHL:  y = {ac[DW-2:0], 1'b0};
            ACS_SHR:  y = {1'b0, ac[DW-1:1]};
            default:  y = ac;
        endcase
    end
endmodule

// File: rtl/mdp_wordmem.sv
module mdp_wordmem #(
    parameter int DW = 16,
    parameter int AW = 11
)(
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[addr] <= wdata;
    end

    assign rdata = store[addr];
endmodule

// File: rtl/uop_datapath.sv
module uop_datapath
    import mdp_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
)(
    input  logic                clk,
    input  logic                rst,
    input  logic [2:0]          f1_op,
    input  logic [2:0]          f2_op,
    input  logic [2:0]          f3_op,
    output logic [DW-1:0]       ac_q,
    output logic [DW-1:0]       dr_q,
    output logic [AW-1:0]       ar_q,
    output logic [AW-1:0]       pc_q,
    output logic                ac_sign,
    output logic                dr_sign,
    output logic                ac_zero,
    output logic [DW-AW-2:0]    dr_opcode
);
    localparam logic [DW-1:0] DR_ONE = DW'(1);
    localparam logic [AW-1:0] PC_ONE = AW'(1);

    ctl_t          ctl;
    logic [DW-1:0] ac_r, dr_r, ac_nx, dr_nx, mem_rd;
    logic [AW-1:0] ar_r, pc_r, ar_nx, pc_nx;

    mdp_decode u_dec (
        .f1_op (f1_op),
        .f2_op (f2_op),
        .f3_op (f3_op),
        .ctl   (ctl)
    );

    mdp_alu #(.DW(DW)) u_alu (
        .sel (ctl.ac_sel),
        .ac  (ac_r),
        .dr  (dr_r),
        .y   (ac_nx)
    );

    mdp_wordmem #(.DW(DW), .AW(AW)) u_mem (
        .clk   (clk),
        .we    (ctl.mem_we),
        .addr  (ar_r),
        .wdata (dr_r),
        .rdata (mem_rd)
    );

    always_comb begin
        case (ctl.dr_sel)
            DRS_MEM: dr_nx = mem_rd;
            DRS_AC:  dr_nx = ac_r;
            DRS_INC: dr_nx = dr_r + DR_ONE;
            DRS_PC:  dr_nx = {dr_r[DW-1:AW], pc_r};
            default: dr_nx = dr_r;
        endcase
        case (ctl.ar_sel)
            ARS_DR:  ar_nx = dr_r[AW-1:0];
            ARS_PC:  ar_nx = pc_r;
            default: ar_nx = ar_r;
        endcase
        case (ctl.pc_sel)
            PCS_INC: pc_nx = pc_r + PC_ONE;
            PCS_AR:  pc_nx = ar_r;
            default: pc_nx = pc_r;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ac_r <= '0;
            dr_r <= '0;
            ar_r <= '0;
            pc_r <= '0;
        end else begin
            ac_r <= ac_nx;
            dr_r <= dr_nx;
            ar_r <= ar_nx;
            pc_r <= pc_nx;
        end
    end

    assign ac_q      = ac_r;
    assign dr_q      = dr_r;
    assign ar_q      = ar_r;
    assign pc_q      = pc_r;
    assign ac_sign   = ac_r[DW-1];
    assign dr_sign   = dr_r[DW-1];
    assign ac_zero   = (ac_r == '0);
    assign dr_opcode = dr_r[DW-2:AW];
endmodule

// File: rtl/uop_datapath_chk.sv
module uop_datapath_chk #(
    parameter int DW = 16,
    parameter int AW = 11
)(
    input logic          clk,
    input logic          rst,
    input logic [2:0]    f1_op,
    input logic [2:0]    f2_op,
    input logic [2:0]    f3_op,
    input logic [DW-1:0] ac_q,
    input logic [DW-1:0] dr_q,
    input logic [AW-1:0] ar_q,
    input logic [AW-1:0] pc_q,
    input logic          ac_zero
);
    // R2
    acc_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (f1_op == 3'b010) |=> (ac_zero && ac_q == '0));

    // R3
    ar_from_dr_chk: assert property (@(posedge clk) disable iff (rst)
        (f1_op == 3'b101) |=> (ar_q == $past(dr_q[AW-1:0])));

    // R3
    ar_from_pc_chk: assert property (@(posedge clk) disable iff (rst)
        (f1_op == 3'b110) |=> (ar_q == $past(pc_q)));

    // R6
    dr_pc_merge_chk: assert property (@(posedge clk) disable iff (rst)
        (f2_op == 3'b111) |=> (dr_q[AW-1:0] == $past(pc_q)
                               && dr_q[DW-1:AW] == $past(dr_q[DW-1:AW])));

    // R8
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (f3_op == 3'b101) |=> (pc_q == $past(pc_q) + 1'b1));

    // R8
    pc_jump_chk: assert property (@(posedge clk) disable iff (rst)
        (f3_op == 3'b110) |=> (pc_q == $past(ar_q)));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (f1_op == 3'b000 && f2_op == 3'b000 && (f3_op == 3'b000 || f3_op == 3'b111))
        |=> ($stable(ac_q) && $stable(dr_q) && $stable(ar_q) && $stable(pc_q)));
endmodule

bind uop_datapath uop_datapath_chk #(.DW(DW), .AW(AW)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .f1_op   (f1_op),
    .f2_op   (f2_op),
    .f3_op   (f3_op),
    .ac_q    (ac_q),
    .dr_q    (dr_q),
    .ar_q    (ar_q),
    .pc_q    (pc_q),
    .ac_zero (ac_zero)
);

// File: tb/uop_datapath_tb_top.sv
module uop_datapath_tb_top;
    import mdp_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  f1 = '0, f2 = '0, f3 = '0;
    logic [15:0] ac_q, dr_q;
    logic [10:0] ar_q, pc_q;
    logic        ac_sign, dr_sign, ac_zero;
    logic [3:0]  dr_opcode;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    uop_datapath dut_i (
        .clk(clk), .rst(rst), .f1_op(f1), .f2_op(f2), .f3_op(f3),
        .ac_q(ac_q), .dr_q(dr_q), .ar_q(ar_q), .pc_q(pc_q),
        .ac_sign(ac_sign), .dr_sign(dr_sign), .ac_zero(ac_zero),
        .dr_opcode(dr_opcode)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive fields at the falling edge, let one rising edge apply them, sample 2 ns later.
    task automatic step(input logic [2:0] a, input logic [2:0] b, input logic [2:0] c);
        @(negedge clk);
        f1 = a; f2 = b; f3 = c;
        @(posedge clk);
        #2;
        f1 = '0; f2 = '0; f3 = '0;
    endtask

    task automatic load_ac(input logic [15:0] v);
        step(F1_ACC_CLR, F2_IDLE, F3_IDLE);
        for (int i = 15; i >= 0; i--) begin
            step(F1_IDLE, F2_IDLE, F3_ACC_SHL);
            if (v[i]) step(F1_ACC_INC, F2_IDLE, F3_IDLE);
        end
    endtask

    task automatic load_dr(input logic [15:0] v);
        load_ac(v);
        step(F1_IDLE, F2_DAT_LDAC, F3_IDLE);
    endtask

    task automatic aim(input logic [10:0] a);
        load_dr({5'b0, a});
        step(F1_ADR_LDDR, F2_IDLE, F3_IDLE);
    endtask

    task automatic poke(input logic [10:0] a, input logic [15:0] d);
        aim(a);
        load_dr(d);
        step(F1_MEM_WR, F2_IDLE, F3_IDLE);
    endtask

    task automatic peek(input logic [10:0] a, output logic [15:0] d);
        aim(a);
        step(F1_IDLE, F2_DAT_LDMEM, F3_IDLE);
        d = dr_q;
    endtask

    task automatic set_pc(input logic [10:0] a);
        aim(a);
        step(F1_IDLE, F2_IDLE, F3_PRG_LDAR);
    endtask

    task automatic fetch();
        step(F1_ADR_LDPC, F2_IDLE, F3_IDLE);
        step(F1_IDLE, F2_DAT_LDMEM, F3_PRG_INC);
    endtask

    task automatic t_reset();
        chk("R1 ac", ac_q, 0);
        chk("R1 dr", dr_q, 0);
        chk("R1 ar", ar_q, 0);
        chk("R1 pc", pc_q, 0);
        chk("R11 zero after reset", ac_zero, 1);
    endtask

    task automatic t_f1_acc();
        load_ac(16'hFFFF);
        chk("R11 ac_sign", ac_sign, 1);
        chk("R11 zero low", ac_zero, 0);
        step(F1_ACC_INC, F2_IDLE, F3_IDLE);
        chk("R2 inc wrap", ac_q, 0);
        chk("R11 zero high", ac_zero, 1);
        load_dr(16'h1234);
        load_ac(16'h0F0F);
        step(F1_ACC_ADD, F2_IDLE, F3_IDLE);
        chk("R2 add", ac_q, 16'h2143);
        step(F1_ACC_LDDR, F2_IDLE, F3_IDLE);
        chk("R2 load dr", ac_q, 16'h1234);
        step(F1_ACC_CLR, F2_IDLE, F3_IDLE);
        chk("R2 clear", ac_q, 0);
    endtask

    task automatic t_logic();
        load_dr(16'h0007);
        load_ac(16'h0005);
        step(F1_IDLE, F2_ACC_SUB, F3_IDLE);
        chk("R5 sub wrap", ac_q, 16'hFFFE);
        load_dr(16'h00F0);
        load_ac(16'h0F0F);
        step(F1_IDLE, F2_ACC_OR, F3_IDLE);
        chk("R5 or", ac_q, 16'h0FFF);
        step(F1_IDLE, F2_IDLE, F3_ACC_XOR);
        chk("R7 xor", ac_q, 16'h0F0F);
        step(F1_IDLE, F2_ACC_AND, F3_IDLE);
        chk("R5 and", ac_q, 16'h0000);
        step(F1_IDLE, F2_IDLE, F3_ACC_NOT);
        chk("R7 not", ac_q, 16'hFFFF);
        load_ac(16'h8001);
        step(F1_IDLE, F2_IDLE, F3_ACC_SHL);
        chk("R7 shl zero fill", ac_q, 16'h0002);
        load_ac(16'h8001);
        step(F1_IDLE, F2_IDLE, F3_ACC_SHR);
        chk("R7 shr zero fill", ac_q, 16'h4000);
    endtask

    task automatic t_dr();
        load_dr(16'hFFFF);
        chk("R11 dr_sign", dr_sign, 1);
        chk("R11 dr_opcode", dr_opcode, 4'hF);
        step(F1_IDLE, F2_DAT_INC, F3_IDLE);
        chk("R6 dr inc wrap", dr_q, 0);
        set_pc(11'h2A5);
        load_dr(16'hF800);
        step(F1_IDLE, F2_DAT_LDPC, F3_IDLE);
        chk("R6 dr low from pc", dr_q, 16'hFAA5);
    endtask

    task automatic t_pc_ar();
        set_pc(11'h7FF);
        step(F1_IDLE, F2_IDLE, F3_PRG_INC);
        chk("R8 pc wrap", pc_q, 0);
        step(F1_ADR_LDPC, F2_IDLE, F3_IDLE);
        chk("R3 ar from pc", ar_q, 0);
        load_dr(16'h1ABC);
        step(F1_ADR_LDDR, F2_IDLE, F3_IDLE);
        chk("R3 ar from dr", ar_q, 11'h2BC);
        step(F1_IDLE, F2_IDLE, F3_PRG_LDAR);
        chk("R8 pc from ar", pc_q, 11'h2BC);
    endtask

    task automatic t_mem();
        logic [15:0] d;
        poke(11'h100, 16'hA5A5);
        poke(11'h101, 16'h5A5A);
        peek(11'h100, d);
        chk("R4 word 100", d, 16'hA5A5);
        peek(11'h101, d);
        chk("R4 word 101", d, 16'h5A5A);
    endtask

    task automatic t_idle();
        logic [15:0] a0, d0;
        logic [10:0] r0, p0;
        load_dr(16'h3C3C);
        load_ac(16'h9999);
        a0 = ac_q; d0 = dr_q; r0 = ar_q; p0 = pc_q;
        step(F1_IDLE, F2_IDLE, F3_SPARE);
        step(F1_IDLE, F2_IDLE, F3_IDLE);
        chk("R9 ac held", ac_q, a0);
        chk("R9 dr held", dr_q, d0);
        chk("R9 ar held", ar_q, r0);
        chk("R9 pc held", pc_q, p0);
    endtask

    task automatic t_concurrent();
        set_pc(11'h005);
        step(F1_ADR_LDPC, F2_IDLE, F3_PRG_INC);
        chk("R10 ar old pc", ar_q, 11'h005);
        chk("R10 pc stepped", pc_q, 11'h006);
        load_dr(16'h00AA);
        step(F1_ACC_CLR, F2_DAT_LDAC, F3_IDLE);
        chk("R10 dr old ac", dr_q, 16'h00AA);
        chk("R10 ac cleared", ac_q, 0);
        load_ac(16'h1111);
        step(F1_ACC_LDDR, F2_DAT_LDAC, F3_IDLE);
        chk("R10 swap ac", ac_q, 16'h00AA);
        chk("R10 swap dr", dr_q, 16'h1111);
    endtask

    task automatic t_add_routine();
        poke(11'h010, 16'h0123);
        poke(11'h123, 16'h7FFF);
        set_pc(11'h010);
        load_ac(16'h0002);
        fetch();
        chk("R12 add opcode", dr_opcode, 4'h0);
        chk("R12 pc advanced", pc_q, 11'h011);
        step(F1_ADR_LDDR, F2_IDLE, F3_IDLE);
        chk("R12 operand addr", ar_q, 11'h123);
        step(F1_IDLE, F2_DAT_LDMEM, F3_IDLE);
        step(F1_ACC_ADD, F2_IDLE, F3_IDLE);
        chk("R12 add result", ac_q, 16'h8001);
        chk("R12 add sign", ac_sign, 1);
    endtask

    task automatic t_xchg_routine();
        logic [15:0] d;
        poke(11'h020, 16'h1855);
        poke(11'h055, 16'hBEEF);
        set_pc(11'h020);
        load_ac(16'h1234);
        fetch();
        chk("R12 xchg opcode", dr_opcode, 4'h3);
        step(F1_ADR_LDDR, F2_IDLE, F3_IDLE);
        step(F1_IDLE, F2_DAT_LDMEM, F3_IDLE);
        step(F1_ACC_LDDR, F2_DAT_LDAC, F3_IDLE);
        step(F1_MEM_WR, F2_IDLE, F3_IDLE);
        chk("R12 xchg ac", ac_q, 16'hBEEF);
        peek(11'h055, d);
        chk("R12 xchg memory", d, 16'h1234);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_f1_acc();
        t_logic();
        t_dr();
        t_pc_ar();
        t_mem();
        t_idle();
        t_concurrent();
        t_add_routine();
        t_xchg_routine();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule